// File: doc/BRIEF.md
# Single-Line Serial Bus Master

This block is the bus master for a single-wire, open-drain serial bus, programmed by a host through three byte-wide registers on a simple synchronous strobe interface. The host can issue a bus reset and learn whether a device answered with a presence pulse. It can queue bytes for transmission and collect the bytes read back during the same time slots. It can also take the line over directly and generate any waveform in software. One active-high interrupt output combines the status flags, each gated by its own enable bit.

All timing is counted in microsecond ticks taken from a clock divider parameter. Each transmitted bit uses one time slot, least significant bit first. Every slot also samples the line, so a byte of all ones reads a byte from a device. Transmit data is double buffered: a holding buffer feeds a shift register. Received data is double buffered as well: a shift register feeds a holding buffer. Both pairs sit behind one host address, where a write goes to the transmit side and a read comes from the receive side.

The search accelerator mode bit is only stored. A reset command clears it.

Top module: `w1m_master`

## Requirements
- R1: A host write to offset 0x4 loads the transmit buffer, and a host read from offset 0x4 returns the receive buffer. The byte read back for each byte sent equals the sent byte ANDed with the bits a device holds low (a 0 from the device forces a 0).
- R2: The command register at offset 0x0 reads as {4'b0, line, drive, search, reset}, with reset in bit 0, search in bit 1, drive in bit 2 and the synchronised live line level in bit 3. Reading it has no side effect. Bit 3 follows the line whatever the drive-enable bit holds.
- R3: Writing bit 0 = 1 to the command register starts a reset and clears bit 1 in the same write. The line is held low for 480 µs. Bit 0 reads 1 until the whole sequence ends 960 µs after it started, and then returns to 0 by itself.
- R4: The line is sampled 70 µs after the reset pulse is released. The presence flag is set at the end of the reset only if the line was low at that sample. Any write to the command register clears the flag.
- R5: A bit slot lasts 65 µs. A 1 holds the line low for 6 µs and a 0 holds it low for 60 µs. The line is sampled 15 µs after the slot starts. Bits go out least significant first.
- R6: When command bit 2 is 1 and drive-enable (bit 7 at offset 0xC) is 1, the line is pulled low continuously and no transfer or reset starts or advances. When drive-enable is 0, bit 2 has no effect on the line.
- R7: The interrupt enable register at offset 0xC holds presence (bit 0), transmit buffer empty (bit 2), transmit shift empty (bit 3), receive buffer full (bit 4), receive shift full (bit 5) and drive-enable (bit 7). Bits 6 and 1 read as 0.
- R8: A write to the transmit buffer clears the transmit-buffer-empty flag. When the shifter is idle, the byte moves into the shifter one cycle later and the flag is set again. The transmit-shift-empty flag is 0 while a byte is being shifted.
- R9: A received byte passes from the receive shifter to the receive buffer when that buffer is empty, and this sets receive-buffer-full. A host read of offset 0x4 clears that flag. While the buffer is still full, the shifter keeps its byte with receive-shift-full set, and no further byte is started.
- R10: irq is 1 exactly when some status flag is 1 together with its enable bit.
- R11: An active-low master reset clears the command and interrupt enable registers, releases the line and drives irq to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | AW (4) | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request, active high |
| line_in | input | 1 | Sensed bus line level |
| line_pull | output | 1 | 1 pulls the open-drain line low |

## Verification
The bench builds the block with CLK_DIV = 2 and keeps the default microsecond timings. This makes one microsecond two clocks, so a full reset sequence takes 1920 cycles and a byte takes about 1040 cycles. At that scale the run has room for a sweep of a dozen transmit and device byte pairs, two reset sequences (one with a device answering and one without), the drive override, and the receive overrun hold. Every low-pulse width is compared in clock cycles against the microsecond figures multiplied by two.

// File: rtl/w1m_pkg.sv
package w1m_pkg;

  localparam int W1M_BITS = 8;

  localparam logic [3:0] ADDR_CMD = 4'h0;
  localparam logic [3:0] ADDR_BUF = 4'h4;
  localparam logic [3:0] ADDR_IEN = 4'hC;

  // writable bits of the enable register (bits 6 and 1 reserved)
  localparam logic [7:0] IEN_MASK = 8'hBD;
  // enable bits that gate interrupt sources (drive-enable excluded)
  localparam logic [7:0] IRQ_SRC_MASK = 8'h3D;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_RST  = 2'd1,
    M_BIT  = 2'd2
  } mode_t;

  // place the status flags on the same bit positions as their enables
  function automatic logic [7:0] flag_vec(input logic pd, input logic tbe,
                                          input logic tsre, input logic rbf,
                                          input logic rsrf);
    return {2'b00, rsrf, rbf, tsre, tbe, 1'b0, pd};
  endfunction

  function automatic logic irq_any(input logic [7:0] flags, input logic [7:0] en);
    return |(flags & en & IRQ_SRC_MASK);
  endfunction

endpackage

// File: rtl/w1m_prescale.sv
module w1m_prescale #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt;

  assign tick = en && (cnt == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (en)      cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/w1m_slot_engine.sv
module w1m_slot_engine
  import w1m_pkg::*;
#(
  parameter int RST_LOW_US   = 480,
  parameter int PRES_SMP_US  = 70,
  parameter int RST_REC_US   = 480,
  parameter int SLOT_US      = 65,
  parameter int W1_LOW_US    = 6,
  parameter int W0_LOW_US    = 60,
  parameter int RD_SMP_US    = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_rst,
  input  logic start_bit,
  input  logic bit_val,
  input  logic line_s,
  output logic busy,
  output logic pull,
  output logic done,
  output logic sample
);
  localparam int CW = $clog2(RST_LOW_US + RST_REC_US + SLOT_US + 1);

  function automatic int low_us(input mode_t m, input logic b);
    if (m == M_RST) return RST_LOW_US;
    if (m == M_BIT) return b ? W1_LOW_US : W0_LOW_US;
    return 0;
  endfunction

  function automatic int samp_us(input mode_t m);
    return (m == M_RST) ? RST_LOW_US + PRES_SMP_US - 1 : RD_SMP_US - 1;
  endfunction

  function automatic int last_us(input mode_t m);
    return (m == M_RST) ? RST_LOW_US + RST_REC_US - 1 : SLOT_US - 1;
  endfunction

  mode_t         mode;
  logic [CW-1:0] cnt;
  logic          bv;
  logic          smp;
  logic          done_q;

  assign busy   = (mode != M_IDLE);
  assign pull   = busy && (cnt < CW'(low_us(mode, bv)));
  assign done   = done_q;
  assign sample = smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_IDLE;
      cnt    <= '0;
      bv     <= 1'b0;
      smp    <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mode == M_IDLE) begin
        if (start_rst) begin
          mode <= M_RST;
          cnt  <= '0;
        end else if (start_bit) begin
          mode <= M_BIT;
          bv   <= bit_val;
          cnt  <= '0;
        end
      end else if (tick) begin
        if (cnt == CW'(samp_us(mode))) smp <= line_s;
        if (cnt == CW'(last_us(mode))) begin
          mode   <= M_IDLE;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // a new slot is only requested while the engine is idle
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rst || start_bit) |-> !busy);
  assert_one_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_rst && start_bit));
endmodule

// File: rtl/w1m_xfer.sv
module w1m_xfer
  import w1m_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_tx,
  input  logic [7:0] wdata,
  input  logic       rd_rx,
  input  logic       rst_pend,
  input  logic       hold,
  input  logic       eng_busy,
  input  logic       eng_done,
  input  logic       eng_sample,
  output logic       start_rst,
  output logic       start_bit,
  output logic       bit_val,
  output logic       rst_done,
  output logic       present,
  output logic [7:0] rx_data,
  output logic       tbe,
  output logic       tsre,
  output logic       rbf,
  output logic       rsrf
);
  localparam int IW = $clog2(W1M_BITS);

  logic [W1M_BITS-1:0] tbuf, tsr, rsr, rbuf;
  logic                tbe_q, tsre_q, rbf_q, rsrf_q;
  logic                byte_act, rst_act;
  logic [IW-1:0]       idx;
  logic                idle, load, bit_done, last_bit;

  assign idle      = !byte_act && !rst_act;
  assign start_rst = !hold && rst_pend && idle;
  assign load      = !hold && !rst_pend && idle && !tbe_q && !rsrf_q;
  assign start_bit = byte_act && !hold && !eng_busy && !eng_done;
  assign bit_val   = tsr[0];
  assign rst_done  = rst_act && eng_done;
  assign present   = !eng_sample;
  assign bit_done  = byte_act && eng_done;
  assign last_bit  = (idx == IW'(W1M_BITS - 1));

  assign rx_data = rbuf;
  assign tbe     = tbe_q;
  assign tsre    = tsre_q;
  assign rbf     = rbf_q;
  assign rsrf    = rsrf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf     <= '0;
      tsr      <= '0;
      rsr      <= '0;
      rbuf     <= '0;
      tbe_q    <= 1'b1;
      tsre_q   <= 1'b1;
      rbf_q    <= 1'b0;
      rsrf_q   <= 1'b0;
      byte_act <= 1'b0;
      rst_act  <= 1'b0;
      idx      <= '0;
    end else begin
      if (start_rst) rst_act <= 1'b1;
      if (rst_done)  rst_act <= 1'b0;

      if (load) begin
        tsr      <= tbuf;
        tbe_q    <= 1'b1;
        tsre_q   <= 1'b0;
        byte_act <= 1'b1;
        idx      <= '0;
      end
      if (wr_tx) begin
        tbuf  <= wdata;
        tbe_q <= 1'b0;
      end

      if (bit_done) begin
        tsr <= tsr >> 1;
        rsr <= {eng_sample, rsr[W1M_BITS-1:1]};
        idx <= idx + 1'b1;
        if (last_bit) begin
          byte_act <= 1'b0;
          tsre_q   <= 1'b1;
          rsrf_q   <= 1'b1;
        end
      end

      if (rsrf_q && !rbf_q) begin
        rbuf   <= rsr;
        rbf_q  <= 1'b1;
        rsrf_q <= 1'b0;
      end else if (rd_rx) begin
        rbf_q <= 1'b0;
      end
    end
  end

  assert_tbe_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !tbe_q);
  assert_rx_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsrf_q && !rbf_q) |=> (rbf_q && !rsrf_q));
endmodule

// File: rtl/w1m_master.sv
module w1m_master
  import w1m_pkg::*;
#(
  parameter int CLK_DIV     = 50,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LOW_US  = 480,
  parameter int PRES_SMP_US = 70,
  parameter int RST_REC_US  = 480,
  parameter int SLOT_US     = 65,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 60,
  parameter int RD_SMP_US   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          irq,
  input  logic          line_in,
  output logic          line_pull
);
  // line synchroniser
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= line_in;
        else             sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate
  assign line_s = sync_q[SYNC_STAGES-1];

  // host decode
  logic cmd_wr, buf_wr, ien_wr, buf_rd;
  assign cmd_wr = host_wr && (host_addr == AW'(ADDR_CMD));
  assign buf_wr = host_wr && (host_addr == AW'(ADDR_BUF));
  assign ien_wr = host_wr && (host_addr == AW'(ADDR_IEN));
  assign buf_rd = host_rd && (host_addr == AW'(ADDR_BUF));

  // registers
  logic       rst_pend, sra, dq_drv, pd;
  logic [7:0] ien_q;
  logic       hold;

  // named internal events
  logic tick, eng_busy, eng_pull, eng_done, eng_sample;
  logic start_rst, start_bit, bit_val, rst_done, present;
  logic [7:0] rx_data;
  logic tbe, tsre, rbf, rsrf;

  assign hold = dq_drv && ien_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend <= 1'b0;
      sra      <= 1'b0;
      dq_drv   <= 1'b0;
      pd       <= 1'b0;
      ien_q    <= '0;
    end else begin
      if (cmd_wr) begin
        dq_drv <= host_wdata[2];
        sra    <= host_wdata[0] ? 1'b0 : host_wdata[1];
      end
      if (cmd_wr && host_wdata[0]) rst_pend <= 1'b1;
      else if (rst_done)           rst_pend <= 1'b0;

      if (rst_done)    pd <= present;
      else if (cmd_wr) pd <= 1'b0;

      if (ien_wr) ien_q <= host_wdata & IEN_MASK;
    end
  end

  w1m_prescale #(.DIV(CLK_DIV)) i_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_rst || start_bit),
    .en    (!hold),
    .tick  (tick)
  );

  w1m_slot_engine #(
    .RST_LOW_US  (RST_LOW_US),
    .PRES_SMP_US (PRES_SMP_US),
    .RST_REC_US  (RST_REC_US),
    .SLOT_US     (SLOT_US),
    .W1_LOW_US   (W1_LOW_US),
    .W0_LOW_US   (W0_LOW_US),
    .RD_SMP_US   (RD_SMP_US)
  ) i_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start_rst (start_rst),
    .start_bit (start_bit),
    .bit_val   (bit_val),
    .line_s    (line_s),
    .busy      (eng_busy),
    .pull      (eng_pull),
    .done      (eng_done),
    .sample    (eng_sample)
  );

  w1m_xfer i_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_tx      (buf_wr),
    .wdata      (host_wdata),
    .rd_rx      (buf_rd),
    .rst_pend   (rst_pend),
    .hold       (hold),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .eng_sample (eng_sample),
    .start_rst  (start_rst),
    .start_bit  (start_bit),
    .bit_val    (bit_val),
    .rst_done   (rst_done),
    .present    (present),
    .rx_data    (rx_data),
    .tbe        (tbe),
    .tsre       (tsre),
    .rbf        (rbf),
    .rsrf       (rsrf)
  );

  assign line_pull = hold || eng_pull;
  assign irq       = irq_any(flag_vec(pd, tbe, tsre, rbf, rsrf), ien_q);

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr == AW'(ADDR_CMD))      host_rdata = {4'b0000, line_s, dq_drv, sra, rst_pend};
    else if (host_addr == AW'(ADDR_BUF)) host_rdata = rx_data;
    else if (host_addr == AW'(ADDR_IEN)) host_rdata = ien_q;
  end

  assert_rst_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_wdata[0]) |=> (rst_pend && !sra));
  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!tick && !start_rst && !start_bit));
  assert_pd_needs_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> $past(rst_done));
endmodule

// File: tb/test_w1m_master.sv
module test_w1m_master;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq, line_pull;
  logic       dev_pull_d = 1'b0, dev_pull_p = 1'b0, ext_pull = 1'b0;
  logic       line_in;

  assign line_in = ~(line_pull | dev_pull_d | dev_pull_p | ext_pull);

  always #10 clk = ~clk;

  w1m_master #(.CLK_DIV(DIV)) i_w1m_master (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .line_in(line_in), .line_pull(line_pull)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // device model state
  bit       dev_present = 1'b1;
  bit       dev_data_en = 1'b0;
  logic [7:0] dev_byte = 8'hFF;
  int       dev_idx = 0;
  int       mon_idx = 0;
  int       slot_w [0:15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_irq(input int maxc, output bit ok);
    ok = 0;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  // pulse width monitor (cycles the master pulls the line low)
  initial begin : mon
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (line_pull) w++;
      else if (w > 0) begin
        slot_w[mon_idx % 16] = w;
        mon_idx++;
        w = 0;
      end
    end
  end

  // device data responder: a 0 bit holds the line low 30 us from slot start
  initial begin : dev_data
    forever begin
      @(posedge line_pull);
      if (dev_data_en) begin
        if (!dev_byte[dev_idx % 8]) begin
          dev_pull_d = 1'b1;
          repeat (30 * DIV) @(negedge clk);
          dev_pull_d = 1'b0;
        end
        dev_idx++;
      end
    end
  end

  // device presence responder after a long low pulse
  initial begin : dev_pres
    int w;
    forever begin
      @(posedge line_pull);
      w = 0;
      while (line_pull) begin @(negedge clk); w++; end
      if (w >= 400 * DIV && dev_present) begin
        repeat (30 * DIV) @(negedge clk);
        dev_pull_p = 1'b1;
        repeat (120 * DIV) @(negedge clk);
        dev_pull_p = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] tx_pat(input int i);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hFF;
    return 8'((i * 8'h35) ^ 8'h96);
  endfunction

  function automatic logic [7:0] dev_pat(input int i);
    if (i < 2) return 8'hFF;
    return 8'(~(i * 8'h1D));
  endfunction

  initial begin : main
    logic [7:0] d;
    bit ok;
    int bad, base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    host_read(4'h0, d); check(d == 8'h08, "R11 cmd reset value", d, 8'h08);
    host_read(4'hC, d); check(d == 8'h00, "R11 ien reset value", d, 8'h00);
    check(irq == 1'b0, "R11 irq idle", irq, 0);
    check(line_pull == 1'b0, "R11 line released", line_pull, 0);

    // R7 enable register layout
    host_write(4'hC, 8'hFF);
    host_read(4'hC, d); check(d == 8'hBD, "R7 reserved bits zero", d, 8'hBD);
    host_write(4'hC, 8'h00);

    // R2 search bit storage
    host_write(4'h0, 8'h02);
    host_read(4'h0, d); check((d & 8'hF7) == 8'h02, "R2 search bit stored", d, 8'h02);

    // R3/R4 reset with device present
    dev_present = 1'b1;
    host_write(4'hC, 8'h01);
    mon_idx = 0;
    host_write(4'h0, 8'h03);
    host_read(4'h0, d); check((d & 8'hF7) == 8'h01, "R3 reset bit set, search cleared", d, 8'h01);
    wait_irq(3000, ok);
    check(ok, "R4 presence flag raised", ok, 1);
    host_read(4'h0, d); check(d[0] == 1'b0, "R3 reset bit self clears", d, 8'h08);
    check(slot_w[0] == 480 * DIV, "R3 reset low width", slot_w[0], 480 * DIV);
    host_read(4'h0, d);
    check(irq == 1'b1, "R2 cmd read has no side effect", irq, 1);
    host_write(4'h0, 8'h00);
    @(negedge clk);
    check(irq == 1'b0, "R4 cmd write clears presence", irq, 0);

    // R4 reset without device
    dev_present = 1'b0;
    host_write(4'h0, 8'h01);
    ok = 0;
    for (int k = 0; k < 2500; k++) begin
      host_read(4'h0, d);
      if (!d[0]) begin ok = 1; break; end
    end
    check(ok, "R3 reset completes without device", ok, 1);
    check(irq == 1'b0, "R4 no presence flag when line high", irq, 0);
    dev_present = 1'b1;

    // R8 transmit buffer empty timing
    host_write(4'hC, 8'h04);
    dev_data_en = 1'b1; dev_byte = 8'hFF; dev_idx = 0;
    host_write(4'h4, 8'hA0);
    check(irq == 1'b0, "R8 tbe cleared by write", irq, 0);
    @(negedge clk);
    check(irq == 1'b1, "R8 tbe set on move to shifter", irq, 1);
    host_write(4'hC, 8'h08);
    check(irq == 1'b0, "R8 shift not empty while sending", irq, 0);
    wait_irq(3000, ok);
    check(ok, "R8 shift empty after byte", ok, 1);
    host_read(4'h4, d); check(d == 8'hA0, "R1 readback with idle device", d, 8'hA0);

    // R1/R5/R9/R10 sweep
    host_write(4'hC, 8'h10);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] tx, dv, rx;
      tx = tx_pat(i); dv = dev_pat(i);
      dev_byte = dv; dev_idx = 0; mon_idx = 0;
      host_write(4'h4, tx);
      wait_irq(3000, ok);
      check(ok, "R9 receive buffer full raised", ok, 1);
      host_read(4'h4, rx);
      check(rx == (tx & dv), "R1 received byte", rx, tx & dv);
      @(negedge clk);
      check(irq == 1'b0, "R9 read clears buffer full", irq, 0);
      bad = 0;
      for (int b = 0; b < 8; b++)
        if (slot_w[b] != (tx[b] ? 6 * DIV : 60 * DIV)) bad++;
      check(bad == 0 && mon_idx == 8, "R5 slot low widths lsb first", bad, 0);
    end

    // R2 live line bit, independent of drive-enable
    host_write(4'hC, 8'h00);
    ext_pull = 1'b1;
    repeat (4) @(negedge clk);
    host_read(4'h0, d); check(d[3] == 1'b0, "R2 line bit follows line", d, 8'h00);
    ext_pull = 1'b0;
    repeat (4) @(negedge clk);

    // R6 drive bit without enable
    host_write(4'h0, 8'h04);
    repeat (4) @(negedge clk);
    check(line_pull == 1'b0, "R6 drive ignored without enable", line_pull, 0);
    host_read(4'h0, d); check(d == 8'h0C, "R6 drive bit stored", d, 8'h0C);

    // R6 drive with enable freezes transfers
    host_write(4'hC, 8'h88);
    check(line_pull == 1'b1, "R6 drive pulls line", line_pull, 1);
    dev_byte = 8'hFF; dev_idx = 0; base = mon_idx;
    host_write(4'h4, 8'h55);
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (!line_pull) bad++;
    end
    check(bad == 0, "R6 line held low", bad, 0);
    check(irq == 1'b1, "R6 no byte starts while driven", irq, 1);
    host_read(4'h0, d); check(d[3] == 1'b0, "R2 line bit shows driven low", d, 8'h04);
    host_write(4'hC, 8'h10);
    host_write(4'h0, 8'h00);
    wait_irq(3000, ok);
    host_read(4'h4, d); check(ok && d == 8'h55, "R6 byte proceeds after release", d, 8'h55);

    // R9 overrun hold
    dev_byte = 8'hC3; dev_idx = 0;
    host_write(4'h4, 8'h3C);
    wait_irq(3000, ok);
    host_write(4'hC, 8'h20);
    host_write(4'h4, 8'hF0);
    wait_irq(3000, ok);
    check(ok, "R9 shift full held", ok, 1);
    base = mon_idx;
    host_write(4'h4, 8'h0F);
    repeat (2100) @(negedge clk);
    check(mon_idx == base, "R9 no byte while shifter full", mon_idx, base);
    host_write(4'hC, 8'h04);
    check(irq == 1'b0, "R10 tbe flag stays low, irq low", irq, 0);
    host_read(4'h4, d); check(d == 8'h00, "R9 first byte", d, 8'h00);
    host_write(4'hC, 8'h10);
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R10 irq from buffer full", irq, 1);
    host_read(4'h4, d); check(d == 8'hC0, "R9 second byte", d, 8'hC0);
    wait_irq(3000, ok);
    host_read(4'h4, d); check(ok && d == 8'h03, "R9 third byte", d, 8'h03);

    // R11 master reset while driving
    host_write(4'hC, 8'h80);
    host_write(4'h0, 8'h04);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(line_pull == 1'b0, "R11 line released by reset", line_pull, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    host_read(4'hC, d); check(d == 8'h00, "R11 ien cleared", d, 8'h00);
    host_read(4'h0, d); check(d == 8'h08, "R11 cmd cleared", d, 8'h08);
    check(irq == 1'b0, "R11 irq low", irq, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule